// File: doc/BRIEF.md
# Dual Converter Channel Sequencer

This block decides which analog input each of two converter units samples, and when. Each unit has four local inputs. A unit runs in one of three modes. In single mode it converts one input. In multi mode it walks once, in ascending order, through a range of inputs that starts at the lowest one. In scan mode it walks the same range again and again until software stops it. Toward each converter the block drives a global channel index and a one-cycle start strobe. It waits for that converter's one-cycle done pulse before it moves on. The first unit covers global channels 0 to 3 and the second covers 4 to 7.

Software reaches the block through a flat word bus with write-enable, address and combinational read data. Each unit has its own control word. A third word holds one shared bit. Setting that bit launches both units together in lockstep: the two strobes of each step fire in the same cycle. The next step waits until every unit still running has reported done. The shared bit clears itself once both units have finished their range. No data stream crosses the block's edge, so every pin is a plain level or pulse and there is no back-pressure.

Top module: `adc_seq_top`

## Requirements
- R1: A unit word (address 0 for the first unit, 1 for the second) holds a 2-bit channel code in bits 1:0. In single mode (mode field bits 3:2 = 00) a run strobes exactly one conversion, on local channel equal to the code.
- R2: In multi mode (mode = 01) a run strobes local channels 0 up to the code, once each and in ascending order, and then the unit goes idle.
- R3: In scan mode (mode = 10 or 11) the unit returns to channel 0 after the coded channel and keeps converting until software writes 0 to its start bit.
- R4: The second unit's index output is its local channel plus 4. The first unit's index equals its local channel.
- R5: While a unit is running, writes to its code and mode fields are ignored. Read-back shows the old values.
- R6: Writing 1 to bit 15 of the shared word (address 2) while both units are idle starts both units. In every step where more than one unit is running, all running units strobe in the same cycle. No unit strobes again until every running unit has received its done pulse. In this run each unit makes one pass, whatever its mode.
- R7: Shared bit 15 reads 1 for the whole shared run and returns to 0 by itself once both units have finished.
- R8: Shared-word bits 14:0 always read 0. Writing them has no effect and starts nothing.
- R9: Reset clears all state. Holding standby high for a cycle clears the shared word to 0x0000 and stops both units.
- R10: A unit's end flag (bit 7) is set when the last channel of a pass completes. A write with bit 7 = 0 clears it, and a write with bit 7 = 1 leaves it unchanged.
- R11: Bit 5 of a unit word reads 1 while the unit runs. Writing 1 while the unit is idle starts a run. Writing 0 while it runs aborts it, and no further strobes follow.
- R12: Each strobe lasts one cycle. A unit issues no new strobe until its done pulse for the previous one has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| standby_i | input | 1 | Standby entry: clears shared word, stops units |
| bus_wr_i | input | 1 | Register write enable |
| bus_addr_i | input | 2 | Register address (0, 1 unit words, 2 shared word) |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data for bus_addr_i (combinational) |
| conv_start_o | output | 2 | Per-unit start-conversion strobe |
| conv_chan_o | output | 6 | Per-unit global channel index, 3 bits per unit, unit 0 in the low bits |
| conv_done_i | input | 2 | Per-unit conversion-done pulse |

## Verification
The assertions check the properties that hold on every cycle. A strobe lasts one cycle. A waiting unit stays put until its done pulse arrives. The current channel stays inside the decoded range. In a shared run, every running unit strobes together. Configuration does not move while a unit runs. An end flag rises only after a done pulse. The shared bit falls only when both units are idle or standby is high. Only the directed scenarios can show the exact channel orders, the offset of the second unit, the scan wrap and abort, the self-clearing of the shared bit, and that a lockstep step really waits for the slower converter. In those scenarios the two converter models use different latencies.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'b00,
    MODE_MULTI    = 2'b01,
    MODE_SCAN     = 2'b10,
    MODE_SCAN_ALT = 2'b11
  } adc_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_WAIT  = 2'b10
  } unit_state_e;

  localparam int REG_W  = 16;
  localparam int MODE_W = 2;
  localparam int GO_BIT = 15;

endpackage

// File: rtl/adc_seq_range.sv
module adc_seq_range
  import adc_seq_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input  logic [CODE_W-1:0] code_i,
  input  adc_mode_e         mode_i,
  output logic [CODE_W-1:0] first_o,
  output logic [CODE_W-1:0] last_o,
  output logic              wrap_o
);

  always_comb begin
    last_o  = code_i;
    first_o = (mode_i == MODE_SINGLE) ? code_i : '0;
    wrap_o  = (mode_i == MODE_SCAN) || (mode_i == MODE_SCAN_ALT);
  end

endmodule

// File: rtl/adc_seq_lockstep.sv
module adc_seq_lockstep #(
  parameter int NUM_UNITS = 2
) (
  input  logic [NUM_UNITS-1:0] busy_i,
  input  logic [NUM_UNITS-1:0] issuing_i,
  output logic                 step_ok_o,
  output logic                 all_idle_o
);

  // A step may fire once no running unit is still waiting for its done pulse.
  assign step_ok_o  = &(~busy_i | issuing_i);
  assign all_idle_o = ~|busy_i;

endmodule

// File: rtl/adc_seq_unit.sv
module adc_seq_unit
  import adc_seq_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kill_i,
  input  logic              go_i,
  input  logic              lockstep_i,
  input  logic              step_ok_i,
  input  logic [CODE_W-1:0] code_i,
  input  adc_mode_e         mode_i,
  input  logic              conv_done_i,
  output logic              conv_start_o,
  output logic [CODE_W-1:0] chan_o,
  output logic              busy_o,
  output logic              issuing_o,
  output logic              pass_done_o
);

  unit_state_e       state_q;
  logic [CODE_W-1:0] cur_q;
  logic [CODE_W-1:0] first;
  logic [CODE_W-1:0] last;
  logic              wrap;

  adc_seq_range #(.CODE_W(CODE_W)) range_i (
    .code_i (code_i),
    .mode_i (mode_i),
    .first_o(first),
    .last_o (last),
    .wrap_o (wrap)
  );

  assign issuing_o    = (state_q == ST_ISSUE);
  assign busy_o       = (state_q != ST_IDLE);
  assign conv_start_o = issuing_o && (!lockstep_i || step_ok_i);
  assign pass_done_o  = (state_q == ST_WAIT) && conv_done_i && (cur_q == last) && !kill_i;
  assign chan_o       = cur_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
    end else if (kill_i) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go_i) begin
            cur_q   <= first;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (conv_start_o) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (conv_done_i) begin
            if (cur_q == last) begin
              if (wrap && !lockstep_i) begin
                cur_q   <= first;
                state_q <= ST_ISSUE;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              cur_q   <= cur_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R12: a strobe never lasts two cycles
  assert_strobe_one_cycle_R12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  // R12: a waiting unit holds until its done pulse
  assert_wait_holds_R12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !conv_done_i && !kill_i) |=> (state_q == ST_WAIT));

  // R2: the walk stays inside the decoded range
  assert_chan_in_range_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cur_q >= first && cur_q <= last));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int NUM_UNITS      = 2,
  parameter int CHANS_PER_UNIT = 4,
  parameter int ADDR_W         = $clog2(NUM_UNITS + 1),
  parameter int CHAN_W         = $clog2(NUM_UNITS * CHANS_PER_UNIT)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        standby_i,
  input  logic                        bus_wr_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [REG_W-1:0]            bus_wdata_i,
  output logic [REG_W-1:0]            bus_rdata_o,
  output logic [NUM_UNITS-1:0]        conv_start_o,
  output logic [NUM_UNITS*CHAN_W-1:0] conv_chan_o,
  input  logic [NUM_UNITS-1:0]        conv_done_i
);

  localparam int CODE_W    = $clog2(CHANS_PER_UNIT);
  localparam int MODE_LSB  = CODE_W;
  localparam int START_BIT = CODE_W + MODE_W + 1;
  localparam int END_BIT   = CODE_W + MODE_W + 3;

  logic [CODE_W-1:0]    cfg_code [NUM_UNITS];
  adc_mode_e            cfg_mode [NUM_UNITS];
  logic [CODE_W-1:0]    unit_chan[NUM_UNITS];
  logic [NUM_UNITS-1:0] end_q, go_q, busy, issuing, pass_done, kill, running, wr_unit;
  logic                 simul_q, step_ok, all_idle, any_running, wr_shared, shared_go;
  logic                 unused_wdata;

  assign unused_wdata = ^{bus_wdata_i[14:8], bus_wdata_i[6], bus_wdata_i[4]};

  assign running     = busy | go_q;
  assign any_running = |running;
  assign wr_shared   = bus_wr_i && (bus_addr_i == ADDR_W'(NUM_UNITS));
  assign shared_go   = wr_shared && bus_wdata_i[GO_BIT] && !any_running && !simul_q && !standby_i;

  adc_seq_lockstep #(.NUM_UNITS(NUM_UNITS)) lock_i (
    .busy_i    (busy),
    .issuing_i (issuing),
    .step_ok_o (step_ok),
    .all_idle_o(all_idle)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                 simul_q <= 1'b0;
    else if (standby_i)          simul_q <= 1'b0;
    else if (shared_go)          simul_q <= 1'b1;
    else if (simul_q && all_idle && !(|go_q)) simul_q <= 1'b0;
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign wr_unit[u] = bus_wr_i && (bus_addr_i == ADDR_W'(u));
    assign kill[u]    = standby_i || (wr_unit[u] && !bus_wdata_i[START_BIT] && running[u]);

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        cfg_code[u] <= '0;
        cfg_mode[u] <= MODE_SINGLE;
        end_q[u]    <= 1'b0;
        go_q[u]     <= 1'b0;
      end else begin
        if (wr_unit[u] && !running[u]) begin
          cfg_code[u] <= bus_wdata_i[CODE_W-1:0];
          cfg_mode[u] <= adc_mode_e'(bus_wdata_i[MODE_LSB +: MODE_W]);
        end
        go_q[u] <= !standby_i && (shared_go ||
                   (wr_unit[u] && bus_wdata_i[START_BIT] && !running[u] && !simul_q));
        if (pass_done[u])                            end_q[u] <= 1'b1;
        else if (wr_unit[u] && !bus_wdata_i[END_BIT]) end_q[u] <= 1'b0;
      end
    end

    adc_seq_unit #(.CODE_W(CODE_W)) unit_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .kill_i      (kill[u]),
      .go_i        (go_q[u]),
      .lockstep_i  (simul_q),
      .step_ok_i   (step_ok),
      .code_i      (cfg_code[u]),
      .mode_i      (cfg_mode[u]),
      .conv_done_i (conv_done_i[u]),
      .conv_start_o(conv_start_o[u]),
      .chan_o      (unit_chan[u]),
      .busy_o      (busy[u]),
      .issuing_o   (issuing[u]),
      .pass_done_o (pass_done[u])
    );

    assign conv_chan_o[u*CHAN_W +: CHAN_W] =
      CHAN_W'(u * CHANS_PER_UNIT) + CHAN_W'(unit_chan[u]);

    // R5: configuration frozen while the unit runs
    assert_cfg_locked_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running[u] && $past(running[u])) |-> ($stable(cfg_code[u]) && $stable(cfg_mode[u])));

    // R10: end flag only rises after a done pulse
    assert_end_after_done_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(end_q[u]) |-> $past(conv_done_i[u]));
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (bus_addr_i == ADDR_W'(u)) begin
        bus_rdata_o[CODE_W-1:0]          = cfg_code[u];
        bus_rdata_o[MODE_LSB +: MODE_W]  = cfg_mode[u];
        bus_rdata_o[START_BIT]           = running[u];
        bus_rdata_o[END_BIT]             = end_q[u];
      end
    end
    if (bus_addr_i == ADDR_W'(NUM_UNITS)) bus_rdata_o[GO_BIT] = simul_q;
  end

  // R6: in a shared run every running unit strobes in the same cycle
  assert_lockstep_strobe_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (simul_q && |conv_start_o) |-> (conv_start_o == busy));

  // R7: the shared bit only falls when both units are idle, or on standby
  assert_shared_clear_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(simul_q) |-> ($past(all_idle) || $past(standby_i)));

  // R8: low bits of the shared word read zero
  assert_shared_low_zero_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(NUM_UNITS)) |-> (bus_rdata_o[GO_BIT-1:0] == '0));

endmodule

// File: tb/adc_seq_top_tb.sv
`timescale 1ns/1ps
module adc_seq_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  conv_start;
  logic [5:0]  conv_chan;
  logic [1:0]  conv_done = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lat [2] = '{2, 4};
  int cnt [2] = '{0, 0};
  int lchan [2][64];
  int lcyc  [2][64];
  int lcnt  [2] = '{0, 0};
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_seq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .conv_start_o(conv_start), .conv_chan_o(conv_chan), .conv_done_i(conv_done)
  );

  // strobe logger and fixed-latency converter models
  always @(negedge clk) begin
    cyc++;
    for (int u = 0; u < 2; u++) begin
      conv_done[u] = 1'b0;
      if (cnt[u] > 0) begin
        cnt[u]--;
        if (cnt[u] == 0) conv_done[u] = 1'b1;
      end
      if (conv_start[u]) begin
        cnt[u] = lat[u];
        if (lcnt[u] < 64) begin
          lchan[u][lcnt[u]] = int'(conv_chan[u*3 +: 3]);
          lcyc[u][lcnt[u]]  = cyc;
        end
        lcnt[u]++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int code, input int mode, input int start, input int endb);
    return 16'((endb << 7) | (start << 5) | (mode << 2) | code);
  endfunction

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = 2'(a);
    #1 d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_log();
    settle(10);
    lcnt[0] = 0; lcnt[1] = 0;
  endtask

  task automatic wait_idle(input int a);
    logic [15:0] d;
    for (int i = 0; i < 400; i++) begin
      rd(a, d);
      if (!d[5]) break;
    end
  endtask

  task automatic check_seq(input int u, input int n, input int base, input int wrapn, input string req);
    check(lcnt[u] >= n, req, lcnt[u], n);
    for (int i = 0; i < n; i++)
      check(lchan[u][i] == base + (i % wrapn), req, lchan[u][i], base + (i % wrapn));
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 3; a++) begin
      rd(a, d);
      check(d == 16'h0, "R9 reset word", int'(d), 0);
    end
    check(conv_start == 2'b00, "R9 reset strobes", int'(conv_start), 0);
  endtask

  task automatic t_single();
    logic [15:0] d;
    clr_log();
    wr(0, mk(2, 0, 1, 1));
    wait_idle(0);
    settle(6);
    check_seq(0, 1, 2, 1, "R1 single unit0");
    check(lcnt[0] == 1, "R1 single count", lcnt[0], 1);
    rd(0, d);
    check(d[7] == 1'b1, "R10 end set", int'(d[7]), 1);
    check(d[5] == 1'b0, "R11 start clears", int'(d[5]), 0);
    wr(1, mk(1, 0, 1, 1));
    wait_idle(1);
    settle(6);
    check_seq(1, 1, 5, 1, "R4 single unit1 offset");
  endtask

  task automatic t_multi();
    clr_log();
    wr(0, mk(3, 1, 1, 1));
    wait_idle(0);
    settle(10);
    check_seq(0, 4, 0, 4, "R2 multi unit0");
    check(lcnt[0] == 4, "R2 multi stops", lcnt[0], 4);
    check(lcyc[0][1] - lcyc[0][0] > lat[0], "R12 waits for done", lcyc[0][1] - lcyc[0][0], lat[0] + 1);
    wr(1, mk(2, 1, 1, 1));
    wait_idle(1);
    settle(10);
    check_seq(1, 3, 4, 3, "R4 multi unit1");
    check(lcnt[1] == 3, "R2 multi unit1 stops", lcnt[1], 3);
  endtask

  task automatic t_scan();
    logic [15:0] d;
    int snap;
    clr_log();
    wr(1, mk(1, 2, 1, 1));
    for (int i = 0; i < 200 && lcnt[1] < 5; i++) @(negedge clk);
    wr(1, mk(1, 2, 0, 1));
    settle(2);
    snap = lcnt[1];
    check_seq(1, 5, 4, 2, "R3 scan wrap");
    settle(20);
    check(lcnt[1] == snap, "R11 abort stops strobes", lcnt[1], snap);
    rd(1, d);
    check(d[5] == 1'b0, "R11 start reads 0 after abort", int'(d[5]), 0);
    check(d[7] == 1'b1, "R10 end set by scan pass", int'(d[7]), 1);
  endtask

  task automatic t_lock();
    logic [15:0] d;
    clr_log();
    wr(0, mk(3, 1, 1, 1));
    wr(0, mk(0, 0, 1, 1));
    rd(0, d);
    check(d[1:0] == 2'd3, "R5 code kept", int'(d[1:0]), 3);
    check(d[3:2] == 2'd1, "R5 mode kept", int'(d[3:2]), 1);
    wait_idle(0);
    settle(10);
    check_seq(0, 4, 0, 4, "R5 run unchanged");
  endtask

  task automatic t_endclr();
    logic [15:0] d;
    wr(0, mk(3, 1, 0, 0));
    rd(0, d);
    check(d[7] == 1'b0, "R10 end cleared", int'(d[7]), 0);
    wr(0, mk(3, 1, 0, 1));
    rd(0, d);
    check(d[7] == 1'b0, "R10 write 1 no effect", int'(d[7]), 0);
  endtask

  task automatic t_shared_ign();
    logic [15:0] d;
    clr_log();
    wr(2, 16'h7FFF);
    rd(2, d);
    check(d == 16'h0, "R8 low bits read 0", int'(d), 0);
    settle(15);
    check(lcnt[0] + lcnt[1] == 0, "R8 no start", lcnt[0] + lcnt[1], 0);
  endtask

  task automatic t_simul();
    logic [15:0] d;
    wr(0, mk(1, 1, 0, 1));
    wr(1, mk(3, 2, 0, 1));
    clr_log();
    wr(2, 16'h8000);
    rd(2, d);
    check(d == 16'h8000, "R7 shared bit set", int'(d), 32768);
    for (int i = 0; i < 300; i++) begin
      rd(2, d);
      if (d == 16'h0) break;
    end
    check(d == 16'h0, "R7 shared self clear", int'(d), 0);
    settle(10);
    check_seq(0, 2, 0, 2, "R6 unit0 pass");
    check_seq(1, 4, 4, 4, "R6 unit1 one pass");
    check(lcnt[1] == 4, "R6 scan unit one pass", lcnt[1], 4);
    check(lcyc[0][0] == lcyc[1][0], "R6 step0 same cycle", lcyc[0][0], lcyc[1][0]);
    check(lcyc[0][1] == lcyc[1][1], "R6 step1 same cycle", lcyc[0][1], lcyc[1][1]);
    check(lcyc[0][1] - lcyc[0][0] > lat[1], "R6 waits slower unit", lcyc[0][1] - lcyc[0][0], lat[1] + 1);
  endtask

  task automatic t_standby();
    logic [15:0] d;
    int snap;
    wr(0, mk(3, 1, 0, 1));
    wr(1, mk(3, 1, 0, 1));
    clr_log();
    wr(2, 16'h8000);
    for (int i = 0; i < 100 && lcnt[0] < 1; i++) @(negedge clk);
    standby = 1'b1;
    @(negedge clk);
    standby = 1'b0;
    rd(2, d);
    check(d == 16'h0, "R9 standby clears shared", int'(d), 0);
    rd(0, d);
    check(d[5] == 1'b0, "R9 standby stops unit0", int'(d[5]), 0);
    rd(1, d);
    check(d[5] == 1'b0, "R9 standby stops unit1", int'(d[5]), 0);
    snap = lcnt[0] + lcnt[1];
    settle(20);
    check(lcnt[0] + lcnt[1] == snap, "R9 no strobes after standby", lcnt[0] + lcnt[1], snap);
  endtask

  initial begin
    settle(4);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_multi();
    t_scan();
    t_lock();
    t_endclr();
    t_shared_ign();
    t_simul();
    t_standby();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule